// File: doc/BRIEF.md
# Peripheral Access Filter Checker

This block sits beside a peripheral interconnect and decides, for every access aimed at one of up to `NUM_PERIPH` peripherals, whether the access may proceed. Each access carries four attributes: a compartment identifier, a secure flag, a privileged flag and the index of the target peripheral. The block compares these attributes against stored configuration and returns a grant bit one clock later.

Each peripheral has its own compartment-filter word. When the filter is off, or when it names compartment 0 as owner, any compartment may reach the peripheral. When the filter names a nonzero owner, only that compartment is let through. When the filter and the shared-use mode are both on, the owner field is ignored and an 8-bit allow list picks which compartments may use the peripheral. Two packed bitmaps, 32 peripherals per word, also mark peripherals that refuse non-secure accesses and peripherals that refuse unprivileged accesses.

A simple synchronous register port writes and reads all of this configuration. It also reads a constant word that describes how large the block was built.

Top module: `periph_access_filter`

## Requirements
- R1: After the synchronous reset, all configuration reads as zero and every access to an in-range peripheral is granted, whatever its attributes.
- R2: The filter word of peripheral n is at byte offset 0x100 + 8·n. Bit 0 is filter enable, bit 1 is shared-use enable, bits 6:4 are the owner compartment and bits 23:16 are the allow list. All other bits read back as zero.
- R3: The secure bitmap words are at 0x10 + 4·k and the privilege bitmap words are at 0x30 + 4·k. Peripheral n is controlled by bit n mod 32 of word n/32, and each word reads back what was written.
- R4: Offset 0xFEC reads {NUM_REGION[7:0], NUM_INIT[7:0], NUM_PERIPH[15:0]} (region count in bits 31:24, initiator count in 23:16, peripheral count in 15:0). Writes to it have no effect.
- R5: With filter enable clear, accesses from any compartment pass the compartment check.
- R6: With filter enable set, shared-use clear and owner 0, accesses from any compartment pass the compartment check.
- R7: With filter enable set, shared-use clear and a nonzero owner, only an access whose compartment equals the owner passes.
- R8: With filter enable and shared-use both set, an access passes only if allow-list bit c (register bit 16 + c) is set for its compartment c. The owner field is ignored.
- R9: Shared-use enable with filter enable clear applies no compartment check.
- R10: A peripheral whose secure bit is set denies non-secure accesses and grants secure ones that pass the other checks.
- R11: A peripheral whose privilege bit is set denies unprivileged accesses.
- R12: A peripheral index of NUM_PERIPH or above is always denied.
- R13: The grant for an access presented in cycle t appears in cycle t+1 and uses the configuration held before any write in cycle t. Read data appears in the cycle after the read request and is zero when no read was requested.
- R14: Unmapped offsets, including misaligned ones inside a register window, read as zero, and writes to them change no configuration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_cid | input | 3 | Compartment identifier of the access |
| acc_secure | input | 1 | Access is secure |
| acc_priv | input | 1 | Access is privileged |
| acc_index | input | IDX_W (8) | Target peripheral index |
| acc_grant | output | 1 | Registered grant decision |
| reg_wr_en | input | 1 | Configuration write strobe |
| reg_rd_en | input | 1 | Configuration read strobe |
| reg_addr | input | ADDR_W (12) | Configuration byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |

## Verification
An access check and a write to the filter word of the same peripheral can land in the same cycle. The bench does this on purpose: in one cycle it writes a restrictive owner into a peripheral that has no filter and presents an access from another compartment to that peripheral. The grant that follows must still reflect the old, open configuration, and only a repeat of the access after the write is denied. Reads and access checks also overlap freely during the random phase. Each result is compared against a bench model that is updated only after the write completes.

// File: rtl/pafc_pkg.sv
package pafc_pkg;
  localparam int CID_W = 3;
  localparam int WL_W  = 1 << CID_W;

  typedef struct packed {
    logic [WL_W-1:0]  wl;
    logic [CID_W-1:0] scid;
    logic             sen;
    logic             fen;
  } cid_cfg_t;
endpackage

// File: rtl/pafc_regfile.sv
module pafc_regfile
  import pafc_pkg::*;
#(
  parameter int NUM_PERIPH = 128,
  parameter int NUM_INIT   = 16,
  parameter int NUM_REGION = 3,
  parameter int ADDR_W     = 12,
  parameter int PIDX_W     = $clog2(NUM_PERIPH)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [31:0]           wdata,
  output logic [31:0]           rdata,
  input  logic [PIDX_W-1:0]     lk_idx,
  output cid_cfg_t              lk_cfg,
  output logic [NUM_PERIPH-1:0] sec_map,
  output logic [NUM_PERIPH-1:0] priv_map
);
  localparam int NWORDS = (NUM_PERIPH + 31) / 32;
  localparam int WSEL_W = (NWORDS > 1) ? $clog2(NWORDS) : 1;
  localparam logic [ADDR_W-1:0] SEC_LO  = ADDR_W'(32'h010);
  localparam logic [ADDR_W-1:0] PRV_LO  = ADDR_W'(32'h030);
  localparam logic [ADDR_W-1:0] CID_LO  = ADDR_W'(32'h100);
  localparam logic [ADDR_W-1:0] HW_ADDR = ADDR_W'(32'hFEC);
  localparam logic [ADDR_W-1:0] MAP_SPAN = ADDR_W'(4 * NWORDS);
  localparam logic [ADDR_W-1:0] CID_SPAN = ADDR_W'(8 * NUM_PERIPH);
  localparam logic [31:0] HW_VAL = {8'(NUM_REGION), 8'(NUM_INIT), 16'(NUM_PERIPH)};

  cid_cfg_t cid_mem [NUM_PERIPH];

  // Offset decode: subtraction wraps below the base, so one compare bounds both ends
  logic [ADDR_W-1:0] sec_off, prv_off, cid_off;
  logic              sec_hit, prv_hit, cid_hit, hw_hit;
  logic [WSEL_W-1:0] sec_w, prv_w;
  logic [PIDX_W-1:0] cid_i;

  assign sec_off = addr - SEC_LO;
  assign prv_off = addr - PRV_LO;
  assign cid_off = addr - CID_LO;
  assign sec_hit = (sec_off < MAP_SPAN) && (sec_off[1:0] == 2'b00);
  assign prv_hit = (prv_off < MAP_SPAN) && (prv_off[1:0] == 2'b00);
  assign cid_hit = (cid_off < CID_SPAN) && (cid_off[2:0] == 3'b000);
  assign hw_hit  = (addr == HW_ADDR);
  assign sec_w   = sec_off[WSEL_W+1:2];
  assign prv_w   = prv_off[WSEL_W+1:2];
  assign cid_i   = cid_off[PIDX_W+2:3];

  // Per-peripheral filter words
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_PERIPH; i++) cid_mem[i] <= '0;
    end else if (wr_en && cid_hit) begin
      cid_mem[cid_i] <= '{wl: wdata[23:16], scid: wdata[6:4], sen: wdata[1], fen: wdata[0]};
    end
  end

  // Packed secure and privilege bitmaps
  always_ff @(posedge clk) begin
    if (rst) begin
      sec_map  <= '0;
      priv_map <= '0;
    end else if (wr_en) begin
      for (int p = 0; p < NUM_PERIPH; p++) begin
        if (sec_hit && int'(sec_w) == p / 32) sec_map[p]  <= wdata[p % 32];
        if (prv_hit && int'(prv_w) == p / 32) priv_map[p] <= wdata[p % 32];
      end
    end
  end

  // Lookup port for the decision path
  always_comb begin
    lk_cfg = '0;
    if (int'(lk_idx) < NUM_PERIPH) lk_cfg = cid_mem[lk_idx];
  end

  // Read mux
  logic [NWORDS*32-1:0] sec_pad, prv_pad;
  logic [31:0]          rd_val;
  cid_cfg_t             rd_cfg;

  assign sec_pad = (NWORDS*32)'(sec_map);
  assign prv_pad = (NWORDS*32)'(priv_map);
  assign rd_cfg  = cid_mem[cid_i];

  always_comb begin
    rd_val = '0;
    if (sec_hit)      rd_val = sec_pad[int'(sec_w)*32 +: 32];
    else if (prv_hit) rd_val = prv_pad[int'(prv_w)*32 +: 32];
    else if (cid_hit) rd_val = {8'b0, rd_cfg.wl, 9'b0, rd_cfg.scid, 2'b00, rd_cfg.sen, rd_cfg.fen};
    else if (hw_hit)  rd_val = HW_VAL;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_en ? rd_val : '0;
  end
endmodule

// File: rtl/pafc_decide.sv
module pafc_decide
  import pafc_pkg::*;
(
  input  cid_cfg_t         cfg,
  input  logic             sec_bit,
  input  logic             priv_bit,
  input  logic             in_range,
  input  logic [CID_W-1:0] acc_cid,
  input  logic             acc_secure,
  input  logic             acc_priv,
  output logic             grant
);
  logic cid_ok, sec_ok, priv_ok;

  always_comb begin
    if (cfg.fen && cfg.sen)                  cid_ok = cfg.wl[acc_cid];
    else if (!cfg.fen || cfg.scid == '0)     cid_ok = 1'b1;
    else                                     cid_ok = (cfg.scid == acc_cid);
  end

  assign sec_ok  = !sec_bit  || acc_secure;
  assign priv_ok = !priv_bit || acc_priv;
  assign grant   = in_range && cid_ok && sec_ok && priv_ok;
endmodule

// File: rtl/periph_access_filter.sv
module periph_access_filter
  import pafc_pkg::*;
#(
  parameter int NUM_PERIPH = 128,
  parameter int NUM_INIT   = 16,
  parameter int NUM_REGION = 3,
  parameter int ADDR_W     = 12,
  parameter int IDX_W      = $clog2(NUM_PERIPH) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CID_W-1:0]  acc_cid,
  input  logic              acc_secure,
  input  logic              acc_priv,
  input  logic [IDX_W-1:0]  acc_index,
  output logic              acc_grant,
  input  logic              reg_wr_en,
  input  logic              reg_rd_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata
);
  localparam int PIDX_W = $clog2(NUM_PERIPH);

  logic [PIDX_W-1:0]     lk_idx;
  logic                  in_range;
  cid_cfg_t              lk_cfg;
  logic [NUM_PERIPH-1:0] sec_map, priv_map;
  logic                  grant_c;

  assign in_range = int'(acc_index) < NUM_PERIPH;
  assign lk_idx   = acc_index[PIDX_W-1:0];

  pafc_regfile #(
    .NUM_PERIPH(NUM_PERIPH), .NUM_INIT(NUM_INIT), .NUM_REGION(NUM_REGION),
    .ADDR_W(ADDR_W), .PIDX_W(PIDX_W)
  ) regs_i (
    .clk(clk), .rst(rst), .wr_en(reg_wr_en), .rd_en(reg_rd_en),
    .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
    .lk_idx(lk_idx), .lk_cfg(lk_cfg), .sec_map(sec_map), .priv_map(priv_map)
  );

  pafc_decide decide_i (
    .cfg(lk_cfg),
    .sec_bit(in_range ? sec_map[lk_idx] : 1'b0),
    .priv_bit(in_range ? priv_map[lk_idx] : 1'b0),
    .in_range(in_range),
    .acc_cid(acc_cid), .acc_secure(acc_secure), .acc_priv(acc_priv),
    .grant(grant_c)
  );

  always_ff @(posedge clk) begin
    if (rst) acc_grant <= 1'b0;
    else     acc_grant <= grant_c;
  end
endmodule

// File: rtl/pafc_checker.sv
module pafc_checker #(
  parameter int NUM_PERIPH = 128,
  parameter int NUM_INIT   = 16,
  parameter int NUM_REGION = 3,
  parameter int ADDR_W     = 12,
  parameter int IDX_W      = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  acc_secure,
  input logic                  acc_priv,
  input logic [IDX_W-1:0]      acc_index,
  input logic                  acc_grant,
  input logic                  reg_rd_en,
  input logic [ADDR_W-1:0]     reg_addr,
  input logic [31:0]           reg_rdata,
  input logic [NUM_PERIPH-1:0] sec_map,
  input logic [NUM_PERIPH-1:0] priv_map
);
  localparam int PIDX_W = $clog2(NUM_PERIPH);
  localparam logic [31:0] HW_VAL = {8'(NUM_REGION), 8'(NUM_INIT), 16'(NUM_PERIPH)};

  logic              in_r;
  logic [PIDX_W-1:0] ci;
  assign in_r = int'(acc_index) < NUM_PERIPH;
  assign ci   = acc_index[PIDX_W-1:0];

  a_r12_out_of_range: assert property (@(posedge clk) disable iff (rst)
    !in_r |=> !acc_grant);

  a_r10_nonsecure_blocked: assert property (@(posedge clk) disable iff (rst)
    (in_r && sec_map[ci] && !acc_secure) |=> !acc_grant);

  a_r11_unpriv_blocked: assert property (@(posedge clk) disable iff (rst)
    (in_r && priv_map[ci] && !acc_priv) |=> !acc_grant);

  a_r4_hwcfg_value: assert property (@(posedge clk) disable iff (rst)
    (reg_rd_en && reg_addr == ADDR_W'(32'hFEC)) |=> (reg_rdata == HW_VAL));

  a_r13_idle_rdata: assert property (@(posedge clk) disable iff (rst)
    !reg_rd_en |=> (reg_rdata == 32'h0));
endmodule

bind periph_access_filter pafc_checker #(
  .NUM_PERIPH(NUM_PERIPH), .NUM_INIT(NUM_INIT), .NUM_REGION(NUM_REGION),
  .ADDR_W(ADDR_W), .IDX_W(IDX_W)
) chk_i (
  .clk(clk), .rst(rst), .acc_secure(acc_secure), .acc_priv(acc_priv),
  .acc_index(acc_index), .acc_grant(acc_grant), .reg_rd_en(reg_rd_en),
  .reg_addr(reg_addr), .reg_rdata(reg_rdata), .sec_map(sec_map), .priv_map(priv_map)
);

// File: tb/periph_access_filter_tb_top.sv
`timescale 1ns/1ps
module periph_access_filter_tb_top;
  localparam int NP = 128;
  localparam int NI = 16;
  localparam int NR = 3;
  localparam logic [31:0] CID_MASK = 32'h00FF_0073;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  acc_cid = '0;
  logic        acc_secure = 1'b0;
  logic        acc_priv = 1'b0;
  logic [7:0]  acc_index = '0;
  logic        acc_grant;
  logic        reg_wr_en = 1'b0;
  logic        reg_rd_en = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] m_cid [NP];
  logic [NP-1:0] m_sec = '0;
  logic [NP-1:0] m_priv = '0;

  always #2.5 clk = ~clk;

  periph_access_filter #(.NUM_PERIPH(NP), .NUM_INIT(NI), .NUM_REGION(NR)) dut_i (
    .clk(clk), .rst(rst), .acc_cid(acc_cid), .acc_secure(acc_secure),
    .acc_priv(acc_priv), .acc_index(acc_index), .acc_grant(acc_grant),
    .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  function automatic bit exp_grant(int cid, bit s, bit pv, int idx);
    logic [31:0] c;
    bit ok;
    if (idx >= NP) return 1'b0;
    c = m_cid[idx];
    if (c[0] && c[1])                 ok = c[16 + cid];
    else if (!c[0] || c[6:4] == 3'd0) ok = 1'b1;
    else                              ok = (int'(c[6:4]) == cid);
    return ok && (!m_sec[idx] || s) && (!m_priv[idx] || pv);
  endfunction

  function automatic logic [31:0] exp_read(logic [11:0] a);
    logic [31:0] v = '0;
    if (a >= 12'h010 && a < 12'h020 && a[1:0] == 2'b00) begin
      for (int b = 0; b < 32; b++) v[b] = m_sec[int'(a - 12'h010) / 4 * 32 + b];
    end else if (a >= 12'h030 && a < 12'h040 && a[1:0] == 2'b00) begin
      for (int b = 0; b < 32; b++) v[b] = m_priv[int'(a - 12'h030) / 4 * 32 + b];
    end else if (a >= 12'h100 && a < 12'h500 && a[2:0] == 3'b000) begin
      v = m_cid[int'(a - 12'h100) / 8];
    end else if (a == 12'hFEC) begin
      v = {8'(NR), 8'(NI), 16'(NP)};
    end
    return v;
  endfunction

  task automatic model_write(logic [11:0] a, logic [31:0] d);
    if (a >= 12'h010 && a < 12'h020 && a[1:0] == 2'b00) begin
      for (int b = 0; b < 32; b++) m_sec[int'(a - 12'h010) / 4 * 32 + b] = d[b];
    end else if (a >= 12'h030 && a < 12'h040 && a[1:0] == 2'b00) begin
      for (int b = 0; b < 32; b++) m_priv[int'(a - 12'h030) / 4 * 32 + b] = d[b];
    end else if (a >= 12'h100 && a < 12'h500 && a[2:0] == 3'b000) begin
      m_cid[int'(a - 12'h100) / 8] = d & CID_MASK;
    end
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic reg_write(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
    model_write(a, d);
  endtask

  task automatic reg_read(string tag, logic [11:0] a);
    @(negedge clk);
    reg_rd_en = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd_en = 1'b0;
    chk(tag, reg_rdata, exp_read(a));
  endtask

  task automatic query(string tag, int cid, bit s, bit pv, int idx);
    @(negedge clk);
    acc_cid = 3'(cid); acc_secure = s; acc_priv = pv; acc_index = 8'(idx);
    @(negedge clk);
    chk(tag, 32'(acc_grant), 32'(exp_grant(cid, s, pv, idx)));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < NP; i++) m_cid[i] = '0;
    void'($urandom(32'h5EED_1234));
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    reg_read("R1 cid reset", 12'h118);
    reg_read("R1 sec reset", 12'h010);
    query("R1 open after reset", 5, 0, 0, 3);

    // R4: hardware configuration, read-only
    reg_read("R4 hwcfg", 12'hFEC);
    reg_write(12'hFEC, 32'hFFFF_FFFF);
    reg_read("R4 hwcfg after write", 12'hFEC);

    // R2: field mask of filter word
    reg_write(12'h100 + 12'd56, 32'hFFFF_FFFF);
    reg_read("R2 cid mask p7", 12'h100 + 12'd56);

    // R14: unmapped and misaligned
    reg_write(12'h104, 32'hFFFF_FFFF);
    reg_read("R14 misaligned read", 12'h104);
    reg_read("R14 p0 unchanged", 12'h100);
    reg_read("R14 gap read", 12'h020);
    reg_read("R14 past cid window", 12'h800);

    // R3: packed bitmaps (p40 -> word 1 bit 8, p127 -> word 3 bit 31)
    reg_write(12'h014, 32'h0000_0100);
    reg_read("R3 sec word1", 12'h014);
    reg_write(12'h03C, 32'h8000_0000);
    reg_read("R3 priv word3", 12'h03C);

    // R10 / R11
    query("R10 nonsecure to secure p40", 2, 0, 1, 40);
    query("R10 secure to secure p40", 2, 1, 1, 40);
    query("R10 nonsecure to p41", 2, 0, 1, 41);
    query("R11 unpriv to priv p127", 1, 1, 0, 127);
    query("R11 priv to priv p127", 1, 1, 1, 127);

    // R5: filter off
    reg_write(12'h100 + 12'd160, 32'h0000_0050);
    query("R5 filter off", 2, 0, 0, 20);
    // R6: filter on, owner 0
    reg_write(12'h100 + 12'd168, 32'h0000_0001);
    query("R6 owner zero", 6, 0, 0, 21);
    // R7: static owner 3
    reg_write(12'h100 + 12'd176, 32'h0000_0031);
    query("R7 owner match", 3, 0, 0, 22);
    query("R7 owner mismatch", 4, 0, 0, 22);
    query("R7 cid0 mismatch", 0, 0, 0, 22);
    // R8: allow list bits 1 and 4, owner 3 ignored
    reg_write(12'h100 + 12'd184, 32'h0012_0033);
    query("R8 list cid1", 1, 0, 0, 23);
    query("R8 list cid4", 4, 0, 0, 23);
    query("R8 owner ignored", 3, 0, 0, 23);
    query("R8 cid0 not listed", 0, 0, 0, 23);
    // R9: shared-use without filter
    reg_write(12'h100 + 12'd192, 32'h0000_0022);
    query("R9 shared without filter", 5, 0, 0, 24);

    // R12: out of range
    query("R12 index 128", 0, 1, 1, 128);
    query("R12 index 255", 0, 1, 1, 255);
    query("R12 index 0 ok", 0, 1, 1, 0);

    // R13: write and query the same peripheral in the same cycle
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = 12'h100 + 12'd72; reg_wdata = 32'h0000_0031;
    acc_cid = 3'd1; acc_secure = 1'b0; acc_priv = 1'b0; acc_index = 8'd9;
    @(negedge clk);
    reg_wr_en = 1'b0;
    chk("R13 same-cycle sees old config", 32'(acc_grant), 32'(exp_grant(1, 0, 0, 9)));
    model_write(12'h100 + 12'd72, 32'h0000_0031);
    query("R13 next access sees new config", 1, 0, 0, 9);

    // Random mix
    for (int it = 0; it < 600; it++) begin
      int op = int'($urandom % 6);
      case (op)
        0: reg_write(12'h100 + 12'(8 * ($urandom % NP)), $urandom);
        1: reg_write(12'h010 + 12'(4 * ($urandom % 4)), $urandom & $urandom);
        2: reg_write(12'h030 + 12'(4 * ($urandom % 4)), $urandom & $urandom);
        3: reg_read("R13 random read", 12'h100 + 12'(8 * ($urandom % NP)));
        default: query("R13 random access", int'($urandom % 8), 1'($urandom),
                       1'($urandom), int'($urandom % 150));
      endcase
    end

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule